// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block holds a 128-byte array and sends its contents, one bit at a time, on a single open-drain style data line. A dedicated transmit clock paces the stream. After power-on reset the line stays released for nine transmit-clock rising edges while the block synchronizes. From the tenth rising edge onward it sends one bit per rising edge. Each byte goes out most significant bit first, and each byte is followed by a null bit. Bytes come from consecutive addresses, and the address wraps from the last location back to the first. The first byte is taken from a starting address that is loaded while reset is held.

A second input, the mode clock, must stay high for streaming to continue. A falling edge on it moves the block into bidirectional mode. In that mode the data line is released for good, and only another power-on reset brings the block back to transmit-only mode. Both slow clocks are sampled in the system clock domain. The array is loaded through a valid/ready write port. That port never applies back-pressure: `wr_ready` is held high, so every cycle with `wr_valid` high writes one byte. A write must not coincide with the read of the same byte, and the bench only loads the array while the stream is idle.

Top module: `txs_streamer`

## Requirements
- R1: While reset is held and after it is released, `sda_oe` is 0, `sda_out` is 1, `bidir_mode` is 0 and `wr_ready` is 1.
- R2: For the first nine rising edges of `tx_clk_in` after reset, `sda_oe` stays 0.
- R3: On the tenth rising edge, `sda_oe` goes to 1 and `sda_out` carries bit 7 of the byte at `start_addr`, the value sampled during reset.
- R4: Each later rising edge presents the next bit, in the order bit 7 down to bit 0.
- R5: After the eight data bits of a byte, the next rising edge gives a null bit: `sda_oe` is 0 and `sda_out` is 1.
- R6: Successive bytes come from successive addresses, and the address after location 127 is location 0.
- R7: A falling edge on `mode_clk_in` sets `bidir_mode` to 1 and `sda_oe` to 0, even in the middle of a byte.
- R8: Once `bidir_mode` is 1, it stays 1 and `sda_oe` stays 0 whatever happens on `tx_clk_in` or `mode_clk_in`. Only reset clears it.
- R9: A cycle with `wr_valid` high writes `wr_data` to `wr_addr`, and the streamed bits reproduce the written bytes.
- R10: The outputs respond exactly three system-clock edges after a change on `tx_clk_in` or `mode_clk_in`, and they hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_addr | input | 7 | Starting byte address, loaded while reset is held |
| tx_clk_in | input | 1 | Transmit clock (asynchronous, slow) |
| mode_clk_in | input | 1 | Mode clock; a falling edge selects bidirectional mode |
| wr_valid | input | 1 | Write request for the array |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_addr | input | 7 | Write address |
| wr_data | input | 8 | Write data |
| sda_out | output | 1 | Serial data value |
| sda_oe | output | 1 | Drive enable for the data line; 0 releases it |
| bidir_mode | output | 1 | 1 once bidirectional mode is entered |

## Verification
A change on either slow clock passes through two synchronizer flops and an edge-history flop, and then updates the output registers. The result is therefore due on the third system-clock edge after the change. The bench drives stimulus on falling system-clock edges. For the tenth transmit edge and for the mode switch, it samples two falling edges after the stimulus, expecting the old value, and three falling edges after, expecting the new value. Every other check is sampled five falling edges after its edge, which is well clear of the update.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned TXS_DEPTH      = 128;
  localparam int unsigned TXS_WIDTH      = 8;
  localparam int unsigned TXS_SYNC_EDGES = 9;
endpackage

// File: rtl/txs_edge_sync.sv
module txs_edge_sync #(
  parameter bit IDLE    = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = s3_q & ~s2_q;
    end else begin : g_rise
      assign edge_o = s2_q & ~s3_q;
    end
  endgenerate

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/txs_byte_store.sv
module txs_byte_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/txs_mode_latch.sv
module txs_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_fall,
  output logic bidir
);
  logic bidir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bidir_q <= 1'b0;
    else if (mode_fall) bidir_q <= 1'b1;
  end

  assign bidir = bidir_q;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_q |=> bidir_q);
  assert_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fall |=> bidir_q);
endmodule

// File: rtl/txs_sequencer.sv
module txs_sequencer #(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_EDGES = 9,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned CW        = $clog2(SYNC_EDGES + 1),
  localparam int unsigned BW        = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    start_addr,
  input  logic             tx_rise,
  input  logic             to_bidir,
  input  logic             bidir,
  output logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rd_data,
  output logic             sda_out,
  output logic             sda_oe
);
  logic [CW-1:0]    sync_cnt_q;
  logic [BW-1:0]    bit_pos_q;
  logic [AW-1:0]    addr_q;
  logic             out_q, oe_q;
  logic [WIDTH-1:0] shifted;
  logic             synced;
  logic             at_null;

  assign shifted = rd_data << bit_pos_q;
  assign synced  = (sync_cnt_q == CW'(SYNC_EDGES));
  assign at_null = (bit_pos_q == BW'(WIDTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt_q <= '0;
      bit_pos_q  <= '0;
      addr_q     <= start_addr;
      out_q      <= 1'b1;
      oe_q       <= 1'b0;
    end else if (bidir || to_bidir) begin
      out_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (tx_rise) begin
      if (!synced) begin
        sync_cnt_q <= sync_cnt_q + 1'b1;
      end else if (at_null) begin
        out_q     <= 1'b1;
        oe_q      <= 1'b0;
        bit_pos_q <= '0;
        addr_q    <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
      end else begin
        out_q     <= shifted[WIDTH-1];
        oe_q      <= 1'b1;
        bit_pos_q <= bit_pos_q + 1'b1;
      end
    end
  end

  assign rd_addr = addr_q;
  assign sda_out = out_q;
  assign sda_oe  = oe_q;

  assert_sync_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !oe_q);
  assert_bidir_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bidir |-> !oe_q);
  assert_null_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rise && synced && at_null) |=> (!oe_q && out_q));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rise && !bidir && !to_bidir && synced && at_null && addr_q == AW'(DEPTH - 1))
    |=> addr_q == '0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rise && !to_bidir) |=> ($stable(oe_q) && $stable(out_q)));
endmodule

// File: rtl/txs_streamer.sv
module txs_streamer
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH      = TXS_DEPTH,
  parameter int unsigned WIDTH      = TXS_WIDTH,
  parameter int unsigned SYNC_EDGES = TXS_SYNC_EDGES,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    start_addr,
  input  logic             tx_clk_in,
  input  logic             mode_clk_in,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic             sda_out,
  output logic             sda_oe,
  output logic             bidir_mode
);
  logic             tx_rise, mode_fall, bidir;
  logic [AW-1:0]    rd_addr;
  logic [WIDTH-1:0] rd_data;

  assign wr_ready = 1'b1;

  txs_edge_sync #(.IDLE(1'b0), .FALLING(1'b0)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .din(tx_clk_in), .edge_o(tx_rise));

  txs_edge_sync #(.IDLE(1'b1), .FALLING(1'b1)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .din(mode_clk_in), .edge_o(mode_fall));

  txs_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .mode_fall(mode_fall), .bidir(bidir));

  txs_byte_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .wr_en(wr_valid & wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  txs_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_EDGES(SYNC_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .tx_rise(tx_rise),
    .to_bidir(mode_fall), .bidir(bidir), .rd_addr(rd_addr), .rd_data(rd_data),
    .sda_out(sda_out), .sda_oe(sda_oe));

  assign bidir_mode = bidir;
endmodule

// File: tb/test_txs_streamer.sv
module test_txs_streamer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] start_addr = 7'd126;
  logic       tx_clk_in = 1'b0;
  logic       mode_clk_in = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sda_out, sda_oe, bidir_mode;

  int n_cmp = 0;
  int n_bad = 0;
  int rc = 0;
  logic [7:0] exp_mem [128];

  always #2 clk = ~clk;

  txs_streamer i_txs_streamer (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .tx_clk_in(tx_clk_in),
    .mode_clk_in(mode_clk_in), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_out(sda_out), .sda_oe(sda_oe),
    .bidir_mode(bidir_mode));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (rise %0d)", req, act, exp, rc);
    end
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [6:0] sa);
    @(negedge clk);
    rst_n = 1'b0; start_addr = sa; tx_clk_in = 1'b0; mode_clk_in = 1'b1;
    wait_neg(3);
    rst_n = 1'b1;
    rc = 0;
    wait_neg(2);
  endtask

  task automatic expected(int k, int sa, output logic oe, output logic bit_v);
    int j, b, p;
    if (k <= 9) begin oe = 1'b0; bit_v = 1'b1; return; end
    j = k - 10; b = j / 9; p = j % 9;
    if (p == 8) begin oe = 1'b0; bit_v = 1'b1; end
    else begin oe = 1'b1; bit_v = exp_mem[(sa + b) % 128][7 - p]; end
  endtask

  task automatic pulse_check(int sa, string req);
    logic eo, eb;
    @(negedge clk);
    tx_clk_in = 1'b1;
    rc++;
    wait_neg(5);
    expected(rc, sa, eo, eb);
    check({req, " oe"}, 32'(sda_oe), 32'(eo));
    if (eo) check({req, " bit"}, 32'(sda_out), 32'(eb));
    else    check({req, " idle level"}, 32'(sda_out), 32'd1);
    tx_clk_in = 1'b0;
    wait_neg(5);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    wait_neg(3);
    check("R1 oe in reset", 32'(sda_oe), 32'd0);
    check("R1 bidir in reset", 32'(bidir_mode), 32'd0);
    check("R1 ready", 32'(wr_ready), 32'd1);
    rst_n = 1'b1;
    wait_neg(3);
    check("R1 oe after reset", 32'(sda_oe), 32'd0);
    check("R1 out after reset", 32'(sda_out), 32'd1);
  endtask

  task automatic t_preload;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 7'(i); wr_data = 8'((i * 29 + 90) & 255);
      exp_mem[i] = wr_data;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    check("R9 ready under writes", 32'(wr_ready), 32'd1);
  endtask

  task automatic t_sync_phase(int sa);
    for (int i = 0; i < 9; i++) pulse_check(sa, "R2 sync");
    @(negedge clk);
    tx_clk_in = 1'b1;
    rc++;
    wait_neg(2);
    check("R10 not yet at two edges", 32'(sda_oe), 32'd0);
    wait_neg(1);
    check("R10 due at third edge / R3 oe", 32'(sda_oe), 32'd1);
    check("R3 first bit is MSB", 32'(sda_out), 32'(exp_mem[sa][7]));
    wait_neg(2);
    tx_clk_in = 1'b0;
    wait_neg(5);
    check("R10 held between edges", 32'(sda_oe), 32'd1);
  endtask

  task automatic t_stream(int sa, int nbits, string req);
    for (int i = 0; i < nbits; i++) pulse_check(sa, req);
  endtask

  task automatic t_mode_switch;
    check("R7 tx mode before fall", 32'(bidir_mode), 32'd0);
    check("R7 mid-byte oe high", 32'(sda_oe), 32'd1);
    @(negedge clk);
    mode_clk_in = 1'b0;
    wait_neg(2);
    check("R10 mode not yet", 32'(bidir_mode), 32'd0);
    wait_neg(1);
    check("R7 bidir set", 32'(bidir_mode), 32'd1);
    check("R7 line released", 32'(sda_oe), 32'd0);
  endtask

  task automatic t_sticky;
    @(negedge clk);
    mode_clk_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tx_clk_in = 1'b1; wait_neg(5);
      check("R8 oe stays low", 32'(sda_oe), 32'd0);
      tx_clk_in = 1'b0; wait_neg(5);
    end
    check("R8 bidir after mode rise", 32'(bidir_mode), 32'd1);
    mode_clk_in = 1'b0;
    wait_neg(5);
    check("R8 bidir after second fall", 32'(bidir_mode), 32'd1);
    check("R8 oe after second fall", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_preload();
    do_reset(7'd126);
    t_sync_phase(126);
    t_stream(126, 7, "R4 msb-first");
    t_stream(126, 1, "R5 null");
    t_stream(126, 9 * 3, "R6 wrap and R9 data");
    t_stream(126, 3, "R4 partial byte");
    t_mode_switch();
    t_sticky();
    do_reset(7'd5);
    check("R8 reset clears bidir", 32'(bidir_mode), 32'd0);
    t_sync_phase(5);
    t_stream(5, 8 + 9 * 2, "R6 second start");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule